// File: doc/BRIEF.md
# Address Translation Buffer with Base-Change Flush

This block keeps a small, fully associative set of recently used page mappings next to a page-table walker. Each entry pairs a 20-bit virtual page number with a 20-bit physical page number for 4 KB pages. A lookup address is compared against every valid entry in the same cycle. On a hit the physical address is formed from the stored page number and the untouched low twelve bits, and the walk through memory is skipped. On a miss the walker fetches the mapping and writes it back through the refill port.

The block also holds the page-directory base value. Loading a new base, as happens on a context switch, invalidates the whole buffer. Loading the value already held leaves every entry in place. The only way to empty the buffer is to write the base register with a different value, and the flush wins over a refill presented in the same cycle.

Top module: `tlb_xlate`

## Requirements
- R1: The lookup is combinational. `lk_hit` goes high in the same cycle that a valid entry's page number equals `lk_vaddr[31:12]`, and `lk_paddr` is then {stored page, `lk_vaddr[11:0]`}. On a miss `lk_hit` is 0 and `lk_paddr` is all zeros.
- R2: A refill (`fill_en` high at a rising edge) stores the mapping `fill_vpn`→`fill_ppn`, and lookups of that page hit from the next cycle on.
- R3: A refill whose page number already sits in a valid entry rewrites that entry in place. It creates no second copy and does not move the replacement pointer.
- R4: The buffer holds 32 entries. While any entry is invalid, a refill of a new page goes to the lowest-numbered invalid entry, so 32 distinct refills after an empty state all stay resident.
- R5: When all 32 entries are valid, a refill of a new page replaces the entry selected by a replacement pointer. The pointer then steps by one and wraps from 31 to 0.
- R6: A base-register write (`root_we`) whose data differs from the held value invalidates every entry and returns the replacement pointer to entry 0. The new value is held from the next cycle.
- R7: A base-register write of the value already held changes no entry.
- R8: When a flushing base write and a refill share a cycle, the flush wins and the refilled mapping is not kept.
- R9: Reset leaves every entry invalid, the base register at zero and the replacement pointer at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | High when a valid entry maps the page of `lk_vaddr` |
| lk_paddr | output | 32 | Translated address on a hit, zero on a miss |
| fill_en | input | 1 | Refill strobe from the walker |
| fill_vpn | input | 20 | Virtual page number being refilled |
| fill_ppn | input | 20 | Physical page number being refilled |
| root_we | input | 1 | Write strobe for the page-directory base register |
| root_wdata | input | 32 | Value written to the base register |

## Verification
Valid bits that fail to clear show up at once as false hits. A lookup in the cycle after a flushing base write still returns the old frame. A replacement pointer that drifts, or that misses its return to zero, stays hidden until the buffer is full again. It then evicts the wrong page, and a later lookup of a page that should be resident misses. A refill that duplicates an existing page instead of rewriting it shows up when that page is read back, because the old frame number mixes into the result. The bench therefore fills the buffer completely twice and probes neighbouring pages right after each eviction.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned TLB_VA_W      = 32;
  localparam int unsigned TLB_PA_W      = 32;
  localparam int unsigned TLB_PAGE_BITS = 12;
  localparam int unsigned TLB_ENTRIES   = 32;

  // how a refill chooses its target entry
  typedef enum logic [1:0] {
    FILL_NONE  = 2'd0,
    FILL_MATCH = 2'd1,
    FILL_FREE  = 2'd2,
    FILL_RR    = 2'd3
  } fill_kind_e;
endpackage

// File: rtl/tlb_root_reg.sv
module tlb_root_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q,
  output logic         flush
);
  // only a change of value empties the buffer
  assign flush = we && (wdata != q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (we) begin
      q <= wdata;
    end
  end
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter int unsigned N     = 32,
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PPN_W = 20,
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [VPN_W-1:0] look_vpn,
  output logic [N-1:0]     look_match,
  output logic             look_hit,
  output logic [PPN_W-1:0] look_ppn,
  output logic [N-1:0]     probe_match,
  output logic [N-1:0]     valid_vec
);
  logic [PPN_W-1:0] masked_ppn [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic             v_q;
    logic [VPN_W-1:0] vpn_q;
    logic [PPN_W-1:0] ppn_q;
    logic             sel;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
      end else if (clr_all) begin
        v_q <= 1'b0;
      end else if (sel) begin
        v_q <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        vpn_q <= wr_vpn;
        ppn_q <= wr_ppn;
      end
    end

    assign valid_vec[g]   = v_q;
    assign look_match[g]  = v_q && (vpn_q == look_vpn);
    assign probe_match[g] = v_q && (vpn_q == wr_vpn);
    assign masked_ppn[g]  = look_match[g] ? ppn_q : '0;
  end

  // at most one entry matches, so an OR tree is a mux
  always_comb begin
    look_ppn = '0;
    for (int i = 0; i < int'(N); i++) begin
      look_ppn = look_ppn | masked_ppn[i];
    end
  end

  assign look_hit = |look_match;
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel
  import tlb_pkg::*;
#(
  parameter int unsigned N     = 32,
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid_vec,
  input  logic [N-1:0]     probe_match,
  input  logic             fill_req,
  input  logic             flush,
  output logic             fill_commit,
  output fill_kind_e       fill_kind,
  output logic [IDX_W-1:0] fill_idx,
  output logic [IDX_W-1:0] rr_ptr
);
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] match_idx;
  logic             any_match;
  logic             all_valid;

  assign any_match = |probe_match;
  assign all_valid = &valid_vec;

  // descending scan leaves the lowest free slot
  always_comb begin
    free_idx = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (!valid_vec[i]) free_idx = IDX_W'(i);
    end
  end

  always_comb begin
    match_idx = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (probe_match[i]) match_idx = IDX_W'(i);
    end
  end

  always_comb begin
    if (!fill_req)       fill_kind = FILL_NONE;
    else if (any_match)  fill_kind = FILL_MATCH;
    else if (!all_valid) fill_kind = FILL_FREE;
    else                 fill_kind = FILL_RR;
  end

  always_comb begin
    case (fill_kind)
      FILL_MATCH: fill_idx = match_idx;
      FILL_FREE:  fill_idx = free_idx;
      default:    fill_idx = rr_ptr;
    endcase
  end

  assign fill_commit = fill_req && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (flush) begin
      rr_ptr <= '0;
    end else if (fill_commit && fill_kind == FILL_RR) begin
      rr_ptr <= (rr_ptr == IDX_W'(N - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int unsigned VA_W      = TLB_VA_W,
  parameter int unsigned PA_W      = TLB_PA_W,
  parameter int unsigned PAGE_BITS = TLB_PAGE_BITS,
  parameter int unsigned ENTRIES   = TLB_ENTRIES
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [VA_W-1:0]           lk_vaddr,
  output logic                      lk_hit,
  output logic [PA_W-1:0]           lk_paddr,
  input  logic                      fill_en,
  input  logic [VA_W-PAGE_BITS-1:0] fill_vpn,
  input  logic [PA_W-PAGE_BITS-1:0] fill_ppn,
  input  logic                      root_we,
  input  logic [VA_W-1:0]           root_wdata
);
  localparam int unsigned VPN_W = VA_W - PAGE_BITS;
  localparam int unsigned PPN_W = PA_W - PAGE_BITS;
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  function automatic logic [VPN_W-1:0] page_num(input logic [VA_W-1:0] va);
    return va[VA_W-1:PAGE_BITS];
  endfunction

  function automatic logic [PAGE_BITS-1:0] page_off(input logic [VA_W-1:0] va);
    return va[PAGE_BITS-1:0];
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [PPN_W-1:0] ppn,
                                              input logic [PAGE_BITS-1:0] off);
    return {ppn, off};
  endfunction

  // named internal events, also observed by the checker
  logic [VA_W-1:0]    root_q;
  logic               flush;
  logic [ENTRIES-1:0] look_match;
  logic [ENTRIES-1:0] probe_match;
  logic [ENTRIES-1:0] valid_vec;
  logic               arr_hit;
  logic [PPN_W-1:0]   arr_ppn;
  logic               fill_commit;
  fill_kind_e         fill_kind;
  logic [IDX_W-1:0]   fill_idx;
  logic [IDX_W-1:0]   rr_ptr;

  tlb_root_reg #(.W(VA_W)) u_root (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (root_we),
    .wdata (root_wdata),
    .q     (root_q),
    .flush (flush)
  );

  tlb_entry_array #(
    .N(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)
  ) u_arr (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_all     (flush),
    .wr_en       (fill_commit),
    .wr_idx      (fill_idx),
    .wr_vpn      (fill_vpn),
    .wr_ppn      (fill_ppn),
    .look_vpn    (page_num(lk_vaddr)),
    .look_match  (look_match),
    .look_hit    (arr_hit),
    .look_ppn    (arr_ppn),
    .probe_match (probe_match),
    .valid_vec   (valid_vec)
  );

  tlb_victim_sel #(.N(ENTRIES), .IDX_W(IDX_W)) u_vsel (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_vec   (valid_vec),
    .probe_match (probe_match),
    .fill_req    (fill_en),
    .flush       (flush),
    .fill_commit (fill_commit),
    .fill_kind   (fill_kind),
    .fill_idx    (fill_idx),
    .rr_ptr      (rr_ptr)
  );

  assign lk_hit   = arr_hit;
  assign lk_paddr = arr_hit ? join_pa(arr_ppn, page_off(lk_vaddr)) : '0;
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
  import tlb_pkg::*;
#(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PA_W      = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned ENTRIES   = 32,
  parameter int unsigned IDX_W     = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [VA_W-1:0]    lk_vaddr,
  input logic               lk_hit,
  input logic [PA_W-1:0]    lk_paddr,
  input logic               fill_en,
  input logic               root_we,
  input logic [VA_W-1:0]    root_wdata,
  input logic [VA_W-1:0]    root_q,
  input logic               flush,
  input logic [ENTRIES-1:0] look_match,
  input logic [ENTRIES-1:0] valid_vec,
  input logic               fill_commit,
  input fill_kind_e         fill_kind,
  input logic [IDX_W-1:0]   rr_ptr
);
  AST_MISS_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_paddr == '0)); // R1
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[PAGE_BITS-1:0] == lk_vaddr[PAGE_BITS-1:0])); // R1
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_match)); // R3
  AST_FILL_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_commit && fill_kind != FILL_NONE) |=>
      ($countones(valid_vec) >= $past($countones(valid_vec)))); // R2
  AST_RR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_commit && fill_kind == FILL_RR) |=>
      (rr_ptr == (($past(rr_ptr) == IDX_W'(ENTRIES - 1)) ? '0 : $past(rr_ptr) + 1'b1))); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0 && rr_ptr == '0)); // R6
  AST_ROOT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    root_we |=> (root_q == $past(root_wdata))); // R6
  AST_SAME_ROOT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (root_we && root_wdata == root_q && !fill_en) |=> $stable(valid_vec)); // R7
  AST_FLUSH_BEATS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && fill_en) |=> ($countones(valid_vec) == 0)); // R8
endmodule

bind tlb_xlate tlb_xlate_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .ENTRIES(ENTRIES), .IDX_W(IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_vaddr    (lk_vaddr),
  .lk_hit      (lk_hit),
  .lk_paddr    (lk_paddr),
  .fill_en     (fill_en),
  .root_we     (root_we),
  .root_wdata  (root_wdata),
  .root_q      (root_q),
  .flush       (flush),
  .look_match  (look_match),
  .valid_vec   (valid_vec),
  .fill_commit (fill_commit),
  .fill_kind   (fill_kind),
  .rr_ptr      (rr_ptr)
);

// File: tb/tlb_xlate_tb.sv
module tlb_xlate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  // vector: op[86:85] (0 lookup, 1 refill, 2 base write), a[84:53], b[52:33], hit[32], pa[31:0]
  localparam logic [86:0] VEC [NVEC] = '{
    {2'd0, 32'h0000_5123, 20'h0,     1'b0, 32'h0000_0000},  // R9 empty after reset
    {2'd1, 32'h0000_0005, 20'hABCDE, 1'b0, 32'h0},
    {2'd0, 32'h0000_5123, 20'h0,     1'b1, 32'hABCD_E123},  // R2
    {2'd0, 32'h0000_6000, 20'h0,     1'b0, 32'h0000_0000},  // R1 miss
    {2'd1, 32'h0000_0006, 20'h11111, 1'b0, 32'h0},
    {2'd0, 32'h0000_6FFF, 20'h0,     1'b1, 32'h1111_1FFF},  // R1 offset
    {2'd2, 32'h0000_0000, 20'h0,     1'b0, 32'h0},          // same as reset value
    {2'd0, 32'h0000_5000, 20'h0,     1'b1, 32'hABCD_E000},  // R7
    {2'd1, 32'h0000_0005, 20'h22222, 1'b0, 32'h0},
    {2'd0, 32'h0000_5ABC, 20'h0,     1'b1, 32'h2222_2ABC},  // R3
    {2'd2, 32'h1234_5000, 20'h0,     1'b0, 32'h0},
    {2'd0, 32'h0000_5ABC, 20'h0,     1'b0, 32'h0000_0000},  // R6
    {2'd0, 32'h0000_6000, 20'h0,     1'b0, 32'h0000_0000},  // R6
    {2'd1, 32'h0000_0007, 20'h33333, 1'b0, 32'h0},
    {2'd2, 32'h1234_5000, 20'h0,     1'b0, 32'h0},
    {2'd0, 32'h0000_7001, 20'h0,     1'b1, 32'h3333_3001}   // R7
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit;
  logic [31:0] lk_paddr;
  logic        fill_en = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_ppn = '0;
  logic        root_we = 1'b0;
  logic [31:0] root_wdata = '0;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tlb_xlate u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_vaddr   (lk_vaddr),
    .lk_hit     (lk_hit),
    .lk_paddr   (lk_paddr),
    .fill_en    (fill_en),
    .fill_vpn   (fill_vpn),
    .fill_ppn   (fill_ppn),
    .root_we    (root_we),
    .root_wdata (root_wdata)
  );

  task automatic report_end();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_fill(input logic [19:0] vpn, input logic [19:0] ppn);
    fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn;
    step();
    fill_en = 1'b0;
  endtask

  task automatic do_root(input logic [31:0] val);
    root_we = 1'b1; root_wdata = val;
    step();
    root_we = 1'b0;
  endtask

  task automatic probe(input logic [31:0] va, input logic eh, input logic [31:0] epa,
                       input string req);
    lk_vaddr = va;
    #1;
    n_run++;
    if (lk_hit !== eh || lk_paddr !== epa) begin
      n_fail++;
      $display("FAIL %s va=%h: hit=%b pa=%h expected hit=%b pa=%h",
               req, va, lk_hit, lk_paddr, eh, epa);
    end
  endtask

  task automatic count_check(input int misses, input string req);
    n_run++;
    if (misses != 0) begin
      n_fail++;
      $display("FAIL %s resident pages missing: actual %0d expected 0", req, misses);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    report_end();
  end

  initial begin
    int misses;
    repeat (3) step();
    rst_n = 1'b1;

    // table walk
    for (int k = 0; k < NVEC; k++) begin
      logic [86:0] v;
      v = VEC[k];
      case (v[86:85])
        2'd0: probe(v[84:53], v[32], v[31:0], "R1/R2/R3/R6/R7 table");
        2'd1: do_fill(v[72:53], v[52:33]);
        default: do_root(v[84:53]);
      endcase
    end

    // R9: reset empties the buffer and zeroes the base
    rst_n = 1'b0; step(); step(); rst_n = 1'b1;
    probe(32'h0000_7001, 1'b0, 32'h0, "R9 entries cleared");
    do_fill(20'h00009, 20'h99999);
    do_root(32'h0);
    probe(32'h0000_9000, 1'b1, 32'h9999_9000, "R9 base zero so no flush");

    // R6: new base flushes
    do_root(32'h0000_1000);
    probe(32'h0000_9000, 1'b0, 32'h0, "R6 flush on new base");

    // R4: 32 refills all resident
    for (int i = 0; i < 32; i++) do_fill(20'(32'h100 + i), 20'(32'h200 + i));
    misses = 0;
    for (int i = 0; i < 32; i++) begin
      lk_vaddr = {20'(32'h100 + i), 12'h0};
      #1;
      if (!lk_hit || lk_paddr !== {20'(32'h200 + i), 12'h0}) misses++;
    end
    count_check(misses, "R4 full buffer");

    // R5: replacement walks from entry 0
    do_fill(20'h00200, 20'hA0000);
    probe(32'h0010_0000, 1'b0, 32'h0, "R5 entry 0 evicted");
    probe(32'h0020_0004, 1'b1, 32'hA000_0004, "R5 new page");
    probe(32'h0010_1000, 1'b1, 32'h0000_0201 << 12, "R5 entry 1 kept");
    do_fill(20'h00201, 20'hA0001);
    probe(32'h0010_1000, 1'b0, 32'h0, "R5 entry 1 evicted");

    // R3: rewrite in place, pointer unchanged
    do_fill(20'h00105, 20'hBEEF0);
    probe(32'h0010_5123, 1'b1, 32'hBEEF_0123, "R3 rewrite");
    do_fill(20'h00202, 20'hA0002);
    probe(32'h0010_2000, 1'b0, 32'h0, "R3 pointer unmoved, entry 2 evicted");
    probe(32'h0010_5000, 1'b1, 32'hBEEF_0000, "R3 rewritten entry kept");
    probe(32'h0010_3000, 1'b1, 32'h0020_3000, "R5 entry 3 kept");

    // R8: flush and refill in one cycle
    root_we = 1'b1; root_wdata = 32'h0000_2000;
    fill_en = 1'b1; fill_vpn = 20'h00300; fill_ppn = 20'hCCCCC;
    step();
    root_we = 1'b0; fill_en = 1'b0;
    probe(32'h0030_0000, 1'b0, 32'h0, "R8 refill dropped");
    probe(32'h0010_3000, 1'b0, 32'h0, "R6 old entries gone");

    // R6: pointer back at 0 after flush (was 3)
    for (int i = 0; i < 32; i++) do_fill(20'(32'h500 + i), 20'(32'h700 + i));
    do_fill(20'h00600, 20'hC0000);
    probe(32'h0050_0000, 1'b0, 32'h0, "R6 pointer reset evicts entry 0");
    probe(32'h0050_3000, 1'b1, 32'h0070_3000, "R6 entry 3 kept");
    probe(32'h0060_0FFF, 1'b1, 32'hC000_0FFF, "R5 replacement hit");

    report_end();
  end
endmodule